// File: doc/BRIEF.md
# CAN Acceptance Filter Evaluator

This block decides, for each completed CAN frame identifier, whether the frame is wanted by each of two receive buffers. Buffer 0 is the stricter, higher-priority buffer and owns two filters. Buffer 1 owns four filters. Each buffer has one mask that it applies to all of its filters. Each filter holds an identifier value and a flag that says whether it is meant for standard or extended frames. A two-bit mode per buffer can:
- leave the filters in charge,
- restrict the buffer to one identifier type, or
- accept everything.

Frames arrive on a valid/ready stream. The frame is taken on a clock edge where `frm_valid` and `frm_ready` are both high. The verdict for both buffers appears on the output stream in the next cycle. A result that has not been taken stays in the output register unchanged. While it waits, `frm_ready` is low, so back-pressure on the result stalls the frame input with no loss. Filters, masks and modes are loaded through a plain write port. A write takes effect for frames taken on any later edge.

Top module: `can_af_top`

## Requirements
- R1: Write address map. Addresses 0 to 5 load filters 0 to 5. In those words, `cfg_wdata[28:0]` is the filter identifier and `cfg_wdata[29]` is the extended flag (1 means extended). Address 6 loads the buffer 0 mask from `cfg_wdata[28:0]`. Address 7 loads the buffer 1 mask from `cfg_wdata[28:0]`. Address 8 loads the buffer 0 mode from `cfg_wdata[1:0]` and the buffer 1 mode from `cfg_wdata[3:2]`.
- R2: Filters 0 and 1 serve buffer 0 and use its mask. Filters 2 to 5 serve buffer 1 and use its mask. Reported indices are these global numbers. A mask bit of 1 requires the identifier bit to equal the filter bit. A mask bit of 0 makes that bit a don't-care.
- R3: Identifier layout and mode 00.
  - A standard identifier sits in `frm_id[28:18]`, and only those 11 bits are compared.
  - An extended identifier uses all of `frm_id[28:0]`.
  - In mode 00 a filter can match only when its extended flag equals `frm_ext`.
- R4: In mode 01 the buffer accepts only standard frames. A filter whose extended flag is 1 never matches.
- R5: In mode 10 the buffer accepts only extended frames. A filter whose extended flag is 0 never matches.
- R6: In mode 11 the buffer accepts every frame. The reported index is the lowest filter that matches under the mode 00 rules, or 0 when none match.
- R7: When several filters of a buffer match, the lowest index is reported.
- R8: When a buffer does not accept the frame, its reported index is 0.
- R9: Result timing and back-pressure.
  - A frame taken on an edge produces `res_valid` with its verdict in the cycle after that edge.
  - While `res_valid` is high and `res_ready` is low, the result stays unchanged and `frm_ready` is low.
- R10: After reset, all filters and masks are zero, both modes are 00, and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| frm_valid | input | 1 | Frame identifier valid |
| frm_ready | output | 1 | Block can take a frame |
| frm_id | input | 29 | Frame identifier (standard in bits 28:18) |
| frm_ext | input | 1 | 1 = extended identifier |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_acc0 | output | 1 | Buffer 0 accepts |
| res_idx0 | output | 3 | Buffer 0 filter index |
| res_acc1 | output | 1 | Buffer 1 accepts |
| res_idx1 | output | 3 | Buffer 1 filter index |

## Verification
A corrupted filter, mask or mode register shows up as a wrong accept bit or index on the very next frame whose identifier touches the corrupted bits. Each such frame's verdict appears one cycle after it is taken. A broken priority encoder shows only when two filters of the same buffer match at once, so such frames are sent on purpose. A fault in the output register or handshake shows up as a result that changes, or a frame that is taken, during a stall. Both are visible within the stalled cycles.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int AF_ID_W  = 29;
  localparam int AF_STD_W = 11;

  typedef enum logic [1:0] {
    AF_MODE_FILT = 2'b00,
    AF_MODE_STD  = 2'b01,
    AF_MODE_EXT  = 2'b10,
    AF_MODE_ALL  = 2'b11
  } af_mode_e;
endpackage

// File: rtl/can_af_cfg.sv
module can_af_cfg
  import can_af_pkg::*;
#(
  parameter int NUM_F  = 6,
  parameter int ID_W   = AF_ID_W,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_F-1:0][ID_W-1:0] flt_id,
  output logic [NUM_F-1:0]           flt_ext,
  output logic [ID_W-1:0]            mask0,
  output logic [ID_W-1:0]            mask1,
  output af_mode_e                   mode0,
  output af_mode_e                   mode1
);
  localparam logic [ADDR_W-1:0] A_MASK0 = ADDR_W'(NUM_F);
  localparam logic [ADDR_W-1:0] A_MASK1 = ADDR_W'(NUM_F + 1);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(NUM_F + 2);

  for (genvar i = 0; i < NUM_F; i++) begin : g_flt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flt_id[i]  <= '0;
        flt_ext[i] <= 1'b0;
      end else if (we && addr == ADDR_W'(i)) begin
        flt_id[i]  <= wdata[ID_W-1:0];
        flt_ext[i] <= wdata[ID_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask0 <= '0;
      mask1 <= '0;
      mode0 <= AF_MODE_FILT;
      mode1 <= AF_MODE_FILT;
    end else if (we) begin
      if (addr == A_MASK0) mask0 <= wdata[ID_W-1:0];
      if (addr == A_MASK1) mask1 <= wdata[ID_W-1:0];
      if (addr == A_MODE) begin
        mode0 <= af_mode_e'(wdata[1:0]);
        mode1 <= af_mode_e'(wdata[3:2]);
      end
    end
  end
endmodule

// File: rtl/can_af_match.sv
module can_af_match
  import can_af_pkg::*;
#(
  parameter int ID_W  = AF_ID_W,
  parameter int STD_W = AF_STD_W
) (
  input  logic [ID_W-1:0] frm_id,
  input  logic            frm_ext,
  input  logic [ID_W-1:0] flt_id,
  input  logic            flt_ext,
  input  logic [ID_W-1:0] mask,
  input  af_mode_e        mode,
  output logic            hit
);
  localparam logic [ID_W-1:0] STD_SPAN = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  logic [ID_W-1:0] span;
  logic            bits_ok;
  logic            type_ok;

  always_comb begin
    span    = frm_ext ? '1 : STD_SPAN;
    bits_ok = ~|((frm_id ^ flt_id) & mask & span);
    type_ok = (frm_ext == flt_ext);
    unique case (mode)
      AF_MODE_STD: hit = type_ok & ~frm_ext & bits_ok;
      AF_MODE_EXT: hit = type_ok &  frm_ext & bits_ok;
      default:     hit = type_ok & bits_ok;
    endcase
  end
endmodule

// File: rtl/can_af_pick.sv
module can_af_pick
  import can_af_pkg::*;
#(
  parameter int N     = 2,
  parameter int BASE  = 0,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hits,
  input  af_mode_e         mode,
  output logic             acc,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (hits[j]) idx = IDX_W'(BASE + j);
    end
    acc = (|hits) | (mode == AF_MODE_ALL);
  end
endmodule

// File: rtl/can_af_top.sv
module can_af_top
  import can_af_pkg::*;
#(
  parameter int NUM_F0 = 2,
  parameter int NUM_F1 = 4,
  parameter int ID_W   = AF_ID_W,
  parameter int STD_W  = AF_STD_W,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int NF    = NUM_F0 + NUM_F1,
  localparam int IDX_W = $clog2(NF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [ID_W-1:0]   frm_id,
  input  logic              frm_ext,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_acc0,
  output logic [IDX_W-1:0]  res_idx0,
  output logic              res_acc1,
  output logic [IDX_W-1:0]  res_idx1
);
  logic [NF-1:0][ID_W-1:0] flt_id;
  logic [NF-1:0]           flt_ext;
  logic [ID_W-1:0]         mask0, mask1;
  af_mode_e                mode0, mode1;
  logic [NF-1:0]           hits;
  logic                    acc0_c, acc1_c;
  logic [IDX_W-1:0]        idx0_c, idx1_c;

  can_af_cfg #(
    .NUM_F(NF), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .flt_id(flt_id), .flt_ext(flt_ext), .mask0(mask0), .mask1(mask1),
    .mode0(mode0), .mode1(mode1)
  );

  for (genvar i = 0; i < NF; i++) begin : g_match
    localparam bit IN_B0 = (i < NUM_F0);
    can_af_match #(.ID_W(ID_W), .STD_W(STD_W)) u_match (
      .frm_id(frm_id), .frm_ext(frm_ext),
      .flt_id(flt_id[i]), .flt_ext(flt_ext[i]),
      .mask(IN_B0 ? mask0 : mask1),
      .mode(IN_B0 ? mode0 : mode1),
      .hit(hits[i])
    );
  end

  can_af_pick #(.N(NUM_F0), .BASE(0), .IDX_W(IDX_W)) u_pick0 (
    .hits(hits[NUM_F0-1:0]), .mode(mode0), .acc(acc0_c), .idx(idx0_c)
  );

  can_af_pick #(.N(NUM_F1), .BASE(NUM_F0), .IDX_W(IDX_W)) u_pick1 (
    .hits(hits[NF-1:NUM_F0]), .mode(mode1), .acc(acc1_c), .idx(idx1_c)
  );

  assign frm_ready = ~res_valid | res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_acc0  <= 1'b0;
      res_idx0  <= '0;
      res_acc1  <= 1'b0;
      res_idx1  <= '0;
    end else if (frm_valid && frm_ready) begin
      res_valid <= 1'b1;
      res_acc0  <= acc0_c;
      res_idx0  <= idx0_c;
      res_acc1  <= acc1_c;
      res_idx1  <= idx1_c;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/can_af_chk.sv
module can_af_chk #(
  parameter int NUM_F0 = 2,
  parameter int NF     = 6,
  parameter int IDX_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_acc0,
  input logic [IDX_W-1:0] res_idx0,
  input logic             res_acc1,
  input logic [IDX_W-1:0] res_idx1
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid &&
      $stable({res_acc0, res_idx0, res_acc1, res_idx1}));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !frm_ready);

  assert_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready |=> res_valid);

  assert_idx0_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_acc0 |-> res_idx0 < IDX_W'(NUM_F0));

  assert_idx1_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_acc1 && res_idx1 != '0 |->
      res_idx1 >= IDX_W'(NUM_F0) && res_idx1 < IDX_W'(NF));

  assert_noacc_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_acc0 || res_idx0 == '0) && (res_acc1 || res_idx1 == '0));

  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |=> !res_valid);
endmodule

bind can_af_top can_af_chk #(.NUM_F0(NUM_F0), .NF(NF), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
  .res_valid(res_valid), .res_ready(res_ready),
  .res_acc0(res_acc0), .res_idx0(res_idx0),
  .res_acc1(res_acc1), .res_idx1(res_idx1)
);

// File: tb/can_af_top_tb.sv
module can_af_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [28:0] frm_id = '0;
  logic        frm_ext = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_acc0, res_acc1;
  logic [2:0]  res_idx0, res_idx1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_af_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_id(frm_id), .frm_ext(frm_ext), .res_valid(res_valid),
    .res_ready(res_ready), .res_acc0(res_acc0), .res_idx0(res_idx0),
    .res_acc1(res_acc1), .res_idx1(res_idx1)
  );

  // {ext, id, acc0, idx0, acc1, idx1}
  localparam logic [37:0] VEC [8] = '{
    {1'b0, 29'h048C0000, 1'b1, 3'd0, 1'b1, 3'd2},  // R7: f2 and f5 both hit
    {1'b0, 29'h048FFFFF, 1'b1, 3'd0, 1'b1, 3'd2},  // R3: low bits ignored
    {1'b1, 29'h00ABCDEF, 1'b1, 3'd1, 1'b0, 3'd0},
    {1'b1, 29'h15551234, 1'b0, 3'd0, 1'b1, 3'd3},  // R2: mask1 hides low bits
    {1'b0, 29'h1FFC0000, 1'b0, 3'd0, 1'b1, 3'd4},
    {1'b1, 29'h048C0000, 1'b0, 3'd0, 1'b0, 3'd0},  // R3: type mismatch
    {1'b0, 29'h04900000, 1'b0, 3'd0, 1'b0, 3'd0},  // R8
    {1'b1, 29'h00ABCDEE, 1'b0, 3'd0, 1'b0, 3'd0}   // R2: mask0 exact
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_chk(string req, logic ext, logic [28:0] id,
                          logic a0, logic [2:0] i0, logic a1, logic [2:0] i1);
    @(negedge clk);
    frm_valid = 1'b1; frm_ext = ext; frm_id = id;
    @(negedge clk);
    frm_valid = 1'b0;
    chk({req, " valid"}, {31'b0, res_valid}, 32'd1);
    chk({req, " result"}, {24'b0, res_acc0, res_idx0, res_acc1, res_idx1},
        {24'b0, a0, i0, a1, i1});
  endtask

  task automatic table_cfg();
    cfg_wr(4'd0, 32'h048C0000);
    cfg_wr(4'd1, 32'h20ABCDEF);
    cfg_wr(4'd2, 32'h048C0000);
    cfg_wr(4'd3, 32'h35550000);
    cfg_wr(4'd4, 32'h1FFC0000);
    cfg_wr(4'd5, 32'h048C0000);
    cfg_wr(4'd6, 32'h1FFFFFFF);
    cfg_wr(4'd7, 32'h1FFF0000);
    cfg_wr(4'd8, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 res_valid in reset", {31'b0, res_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 res_valid after reset", {31'b0, res_valid}, 32'd0);
    chk("R10 frm_ready after reset", {31'b0, frm_ready}, 32'd1);
    send_chk("R10 zero config std", 1'b0, 29'h0, 1'b1, 3'd0, 1'b1, 3'd2);
    send_chk("R10 zero config ext", 1'b1, 29'h0, 1'b0, 3'd0, 1'b0, 3'd0);

    table_cfg();  // R1
    for (int k = 0; k < 8; k++) begin
      send_chk($sformatf("R1 R2 R3 table %0d", k), VEC[k][37], VEC[k][36:8],
               VEC[k][7], VEC[k][6:4], VEC[k][3], VEC[k][2:0]);
    end

    // R9: back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    frm_valid = 1'b1; frm_ext = 1'b0; frm_id = 29'h048C0000;
    @(negedge clk);
    frm_id = 29'h1FFC0000;
    for (int c = 0; c < 3; c++) begin
      chk("R9 stall valid", {31'b0, res_valid}, 32'd1);
      chk("R9 stall ready low", {31'b0, frm_ready}, 32'd0);
      chk("R9 stall result held",
          {24'b0, res_acc0, res_idx0, res_acc1, res_idx1},
          {24'b0, 1'b1, 3'd0, 1'b1, 3'd2});
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R9 second frame after stall",
        {24'b0, res_valid, res_acc0, res_idx0, res_acc1, res_idx1},
        {24'b0, 1'b1, 1'b0, 3'd0, 1'b1, 3'd4});

    cfg_wr(4'd8, 32'h1);  // buffer 0 standard only
    send_chk("R4 ext rejected", 1'b1, 29'h00ABCDEF, 1'b0, 3'd0, 1'b0, 3'd0);
    send_chk("R4 std accepted", 1'b0, 29'h048C0000, 1'b1, 3'd0, 1'b1, 3'd2);

    cfg_wr(4'd8, 32'h2);  // buffer 0 extended only
    send_chk("R5 std rejected", 1'b0, 29'h048C0000, 1'b0, 3'd0, 1'b1, 3'd2);
    send_chk("R5 ext accepted", 1'b1, 29'h00ABCDEF, 1'b1, 3'd1, 1'b0, 3'd0);

    cfg_wr(4'd8, 32'hC);  // buffer 1 accept all
    send_chk("R6 no match index 0", 1'b0, 29'h04900000, 1'b0, 3'd0, 1'b1, 3'd0);
    send_chk("R6 match index", 1'b1, 29'h15551234, 1'b0, 3'd0, 1'b1, 3'd3);

    cfg_wr(4'd8, 32'h0);
    cfg_wr(4'd1, 32'h048C0000);
    send_chk("R7 lowest of f0 f1", 1'b0, 29'h048C0000, 1'b1, 3'd0, 1'b1, 3'd2);
    cfg_wr(4'd0, 32'h1FFC0000);
    send_chk("R7 R1 f1 after f0 rewrite", 1'b0, 29'h048C0000,
             1'b1, 3'd1, 1'b1, 3'd2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule